// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

The block delays a parallel data word by a chosen whole number of clock cycles, from zero up to sixty-three. The delay is built from six register chains whose lengths are powers of two, arranged from the longest at the input to the shortest at the output. Each chain can be skipped by a two-way selector that one bit of a six-bit delay selector controls. The total delay equals the binary value of that selector.

A selector value of zero makes the output a purely combinational copy of the input. Every chain shifts on every clock, including while it is skipped, so its contents always follow the data it is fed. The selector may change at any time. After a change the output follows the new delay once the newly selected path has filled with data entered after the change, which takes at most sixty-three cycles. The switch itself is not glitch-free. The data path is a free-running stream with no handshake, because a fixed cycle count cannot be held up by back-pressure. The active-low reset clears every stage.

Top module: `tdl_delay_line`

## Requirements
- R1: While reset is low and for the first D cycles after it rises, the output reads zero whenever the selector value D is non-zero, because every stage is cleared by reset.
- R2: With the selector at zero, the output equals the input in the same cycle, with no register on the path.
- R3: With the selector held at a value D, the output in each cycle equals the input that was applied D cycles earlier.
- R4: Selector bit k adds exactly 2^k cycles of delay. Bit 5 controls the 32-stage chain nearest the input, and bit 0 controls the single stage nearest the output.
- R5: After any change of the selector to a new value D, the output equals the input delayed by D cycles no later than 63 cycles after the change, including when D is smaller than the old value.
- R6: The largest selector value, all ones, gives a delay of exactly 63 cycles, and every bit of the data word is delayed identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst_n | input | 1 | Active-low asynchronous reset; clears all stages |
| delay_sel | input | CTL_W (6) | Delay in cycles; bit k switches in the 2^k-stage chain |
| din | input | DATA_W (8) | Data word entering the line |
| dout | output | DATA_W (8) | Data word leaving the line |

## Verification
A selector change and the arrival of a new data word can happen in the same cycle. The old path is still draining while the newly selected chains begin to receive the word. The bench provokes this by changing the selector on the same edge on which it applies a fresh random word. It then ignores the output for the 63-cycle settling window and compares the output against its own history of applied words at the new delay. Zero-delay and reset cases are compared in the cycle itself, because the output there must not lag the input.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // number of binary-weighted chains and the data width used by default
  localparam int unsigned TDL_SECTIONS = 6;
  localparam int unsigned TDL_DATA_W   = 8;

  // length of the chain governed by selector bit k
  function automatic int unsigned chain_len(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // total delay reachable with all selector bits set
  function automatic int unsigned max_delay(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction
endpackage

// File: rtl/tdl_section.sv
module tdl_section #(
  parameter int unsigned W   = 8,
  parameter int unsigned LEN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [LEN-1:0][W-1:0] stages;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= {stages[LEN-2:0], d};
      end
    end
  endgenerate

  assign q = stages[LEN-1];
endmodule

// File: rtl/tdl_bypass_mux.sv
module tdl_bypass_mux #(
  parameter int unsigned W = 8
) (
  input  logic         take_delayed,
  input  logic [W-1:0] straight,
  input  logic [W-1:0] delayed,
  output logic [W-1:0] y
);
  always_comb begin
    y = take_delayed ? delayed : straight;
  end
endmodule

// File: rtl/tdl_delay_line.sv
module tdl_delay_line
  import tdl_pkg::*;
#(
  parameter int unsigned DATA_W = TDL_DATA_W,
  parameter int unsigned CTL_W  = TDL_SECTIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  delay_sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  // tap[CTL_W] is the line input; tap[k] is the value after chain k's selector
  logic [CTL_W:0][DATA_W-1:0]   tap;
  logic [CTL_W-1:0][DATA_W-1:0] chain_q;

  assign tap[CTL_W] = din;

  generate
    for (genvar k = CTL_W - 1; k >= 0; k--) begin : g_stage
      localparam int unsigned LEN_K = chain_len(k);

      tdl_section #(.W(DATA_W), .LEN(LEN_K)) sect_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (tap[k+1]),
        .q    (chain_q[k])
      );

      tdl_bypass_mux #(.W(DATA_W)) sel_i (
        .take_delayed(delay_sel[k]),
        .straight    (tap[k+1]),
        .delayed     (chain_q[k]),
        .y           (tap[k])
      );
    end
  endgenerate

  assign dout = tap[0];
endmodule

// File: rtl/tdl_delay_line_chk.sv
module tdl_delay_line_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTL_W-1:0]  delay_sel,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout
);
  // edges seen since reset released, saturating
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1: first edge after reset, a non-zero delay still shows cleared stages
  assert_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd0 && delay_sel != '0) |-> dout == '0);

  // R2: zero selector is a straight wire
  assert_zero_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_sel == '0) |-> dout == din);

  // R4: bit 0 alone gives one cycle
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && delay_sel == 1 && $past(delay_sel) == 1)
      |-> dout == $past(din));

  // R4: bit 1 alone gives two cycles
  assert_two_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd2 && delay_sel == 2 && $past(delay_sel) == 2 &&
     $past(delay_sel, 2) == 2) |-> dout == $past(din, 2));

  // R3: bits 1 and 0 together give three cycles
  assert_three_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && delay_sel == 3 && $past(delay_sel) == 3 &&
     $past(delay_sel, 2) == 3 && $past(delay_sel, 3) == 3)
      |-> dout == $past(din, 3));
endmodule

bind tdl_delay_line tdl_delay_line_chk #(.DATA_W(DATA_W), .CTL_W(CTL_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .delay_sel(delay_sel),
  .din      (din),
  .dout     (dout)
);

// File: tb/tdl_delay_line_tb_top.sv
`timescale 1ns/1ps
module tdl_delay_line_tb_top;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int MAXD = 63;
  localparam int NVEC = 12;
  // stimulus selector values and the delay each must produce
  localparam int VEC_SEL [NVEC] = '{1, 2, 4, 8, 16, 32, 3, 21, 42, 62, 63, 0};
  localparam int VEC_DLY [NVEC] = '{1, 2, 4, 8, 16, 32, 3, 21, 42, 62, 63, 0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] delay_sel = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] hist [MAXD+1];

  always #2.5 clk = ~clk;

  tdl_delay_line #(.DATA_W(DW), .CTL_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .delay_sel(delay_sel), .din(din), .dout(dout)
  );

  task automatic check(input string req, input logic [DW-1:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%0h expected=%0h sel=%0d", req, dout, exp, delay_sel);
    end
  endtask

  // drive one cycle: new selector and word at the falling edge, compare 1 ns later
  task automatic step(input int sel, input logic [DW-1:0] w, input int d,
                      input bit do_chk, input string req);
    @(negedge clk);
    delay_sel = sel[CW-1:0];
    for (int i = MAXD; i > 0; i--) hist[i] = hist[i-1];
    din = w;
    hist[0] = w;
    #1;
    if (do_chk) check(req, hist[d]);
  endtask

  task automatic run_sel(input int sel, input int d, input string req);
    for (int i = 0; i < MAXD; i++) step(sel, DW'($urandom), d, 1'b0, req);
    for (int i = 0; i < 8; i++) step(sel, DW'($urandom), d, 1'b1, req);
  endtask

  initial begin
    for (int i = 0; i <= MAXD; i++) hist[i] = '0;
    // R1: held in reset with full delay selected
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", '0);
    // release; the next 63 outputs must still be cleared, then R6 exact 63
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < MAXD; i++) step(63, DW'($urandom), 63, 1'b1, "R1");
    for (int i = 0; i < 8; i++) step(63, DW'($urandom), 63, 1'b1, "R6");

    // table walk: single-bit weights (R4) and mixed values (R3)
    for (int v = 0; v < NVEC; v++)
      run_sel(VEC_SEL[v], VEC_DLY[v], (VEC_SEL[v] & (VEC_SEL[v]-1)) == 0 ? "R4" : "R3");

    // R2: zero delay, same-cycle copy for extreme patterns
    step(0, 8'h00, 0, 1'b1, "R2");
    step(0, 8'hFF, 0, 1'b1, "R2");
    step(0, 8'h55, 0, 1'b1, "R2");
    step(0, 8'hAA, 0, 1'b1, "R2");

    // R6: all-ones and alternating words through the longest path
    run_sel(63, 63, "R6");
    for (int i = 0; i < 4; i++) step(63, (i % 2) ? 8'hAA : 8'hFF, 63, 1'b0, "R6");
    for (int i = 0; i < MAXD; i++) step(63, 8'h00, 63, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(63, 8'h00, 63, 1'b1, "R6");

    // R5: full sweep, selector changed on the same edge as new data
    for (int s = 0; s < 64; s++) run_sel(s, s, "R5");
    // R5: shrink from the longest to a short delay mid-stream
    run_sel(63, 63, "R5");
    run_sel(5, 5, "R5");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: dout=%0h expected=finish", dout);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule